// File: doc/BRIEF.md
# Add/Subtract Instruction Decode-Execute Unit

This unit takes one 32-bit instruction word per cycle in which `insn_valid` is high and executes it if it is one of three non-carry add/subtract forms. The forms are immediate, shifted register and extended register. From the word it derives the two register read addresses. It reads the operands through an external register file whose read data returns in the same cycle. It then forms the second operand by scaling the immediate, shifting the register, or extending and shifting the register. Next it adds or subtracts, and one clock later it issues a write-back of the destination together with an optional update of the condition flags.

Register number 31 has two meanings. In the immediate and extended forms, a base register of 31 means the stack pointer, and so does a destination of 31 when flags are not set. Everywhere else, 31 means the zero register: it reads as zero and writes to it are dropped. Reserved encodings, and words that belong to none of the three forms, raise a one-cycle undefined pulse instead of a write-back.

Top module: `addsub_exec`

## Requirements
- R1: Common fields: bit 31 = 1 selects 64-bit width and 0 selects 32-bit width; bit 30 = 1 subtracts and 0 adds; bit 29 = 1 sets flags; bits 9:5 give the first register (Rn) and bits 4:0 give the destination (Rd). The result is first operand plus or minus second operand and is written to Rd.
- R2: Immediate form: bits 28:24 = 10001, with a 12-bit immediate in bits 21:10 and a shift code in bits 23:22. Code 00 uses the immediate as is. Code 01 shifts it left by 12. Codes 10 and 11 are undefined.
- R3: Shifted-register form: bits 28:24 = 01011 and bit 21 = 0, with Rm in bits 20:16, the amount in bits 15:10 and the type in bits 23:22. Type 00 is a logical left shift, 01 a logical right shift and 10 an arithmetic right shift. Type 11 is undefined, and so is an amount above 31 in 32-bit mode.
- R4: Extended-register form: bits 28:24 = 01011 and bit 21 = 1, with Rm in bits 20:16, the option in bits 15:13 and the left-shift amount in bits 12:10. Option bits 1:0 take the low 8, 16, 32 or 64 bits of Rm for codes 0 to 3. Option bit 2 selects sign extension when 1 and zero extension when 0. The extended value is shifted left by the amount. An amount above 4 is undefined.
- R5: In the immediate and extended forms, Rn = 31 reads the stack pointer (`rd_sp_a` high). Rd = 31 writes the stack pointer (`wb_sp` high) when bit 29 is 0. When bit 29 is 1, Rd = 31 is the zero register and the write is dropped.
- R6: In the shifted-register form, register 31 in any field is the zero register: it reads as zero and a write to it is dropped. In both register forms, Rm = 31 reads as zero.
- R7: In 32-bit mode only the low 32 bits of the operands are used, flags come from the 32-bit result, and the written value is that result zero-extended to 64 bits.
- R8: `flags` is {N,Z,C,V} in bits 3 down to 0. N is the result sign, Z is set for a zero result, C is the carry out (for subtract, no borrow), and V is signed overflow. The flags update, with `flags_we` pulsed, only when bit 29 is set; otherwise they hold.
- R9: A word matching none of the forms, or any undefined encoding, pulses `undef` and produces no write-back and no flag change.
- R10: `wb_en`, `flags_we` and `undef` are single-cycle pulses one clock after the valid strobe; with no valid strobe none of them is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | Instruction word valid this cycle |
| insn | input | 32 | Instruction word |
| rd_addr_a | output | 5 | Read port A address (Rn) |
| rd_sp_a | output | 1 | Read port A addresses the stack pointer |
| rd_data_a | input | 64 | Read port A data, same cycle |
| rd_addr_b | output | 5 | Read port B address (Rm) |
| rd_data_b | input | 64 | Read port B data, same cycle |
| wb_en | output | 1 | Write-back strobe |
| wb_addr | output | 5 | Write-back register number |
| wb_sp | output | 1 | Write-back targets the stack pointer |
| wb_data | output | 64 | Write-back value |
| flags_we | output | 1 | Flags updated this cycle |
| flags | output | 4 | Current {N,Z,C,V} |
| undef | output | 1 | Undefined-instruction strobe |

## Verification
The bench builds the unit with its default 64-bit datapath, so the 32-bit half width is also in play. Both widths can then be mixed in one run. The full 6-bit shift range of the shifted form is reachable in 64-bit mode, and amounts of 32 to 63 in 32-bit mode can be driven to hit the undefined rule. The register model behind the read ports holds a non-zero value in entry 31 and a separate stack-pointer value, so a wrong zero-register or stack-pointer choice shows up in the written data.

// File: rtl/addsub_pkg.sv
// Shared types and constants for the add/subtract decode-execute unit.
// Assumes a fixed 32-bit instruction word and 32 architectural registers.
package addsub_pkg;
    localparam int INSN_W  = 32;
    localparam int RADDR_W = 5;

    // Which operand-forming format the word belongs to
    typedef enum logic [1:0] {
        FMT_NONE = 2'd0,
        FMT_IMM  = 2'd1,
        FMT_SREG = 2'd2,
        FMT_XREG = 2'd3
    } fmt_e;
endpackage

// File: rtl/addsub_decode.sv
// Field decoder: classifies the word into a format, flags reserved
// encodings and resolves what register 31 means in each position.
// Purely combinational; assumes the word is stable while valid.
module addsub_decode
    import addsub_pkg::*;
(
    input  logic [INSN_W-1:0]  insn,
    output fmt_e               fmt,
    output logic               wide,
    output logic               sub,
    output logic               setf,
    output logic [RADDR_W-1:0] rn,
    output logic [RADDR_W-1:0] rm,
    output logic [RADDR_W-1:0] rd,
    output logic [1:0]         kind,
    output logic [5:0]         amt6,
    output logic [2:0]         xopt,
    output logic [2:0]         xamt,
    output logic [11:0]        imm12,
    output logic               bad,
    output logic               rn_is_sp,
    output logic               rn_zero,
    output logic               rm_zero,
    output logic               rd_sp,
    output logic               rd_drop
);
    localparam logic [RADDR_W-1:0] REG31 = '1;

    logic sp_format;

    assign wide  = insn[31];
    assign sub   = insn[30];
    assign setf  = insn[29];
    assign kind  = insn[23:22];
    assign rm    = insn[20:16];
    assign amt6  = insn[15:10];
    assign xopt  = insn[15:13];
    assign xamt  = insn[12:10];
    assign imm12 = insn[21:10];
    assign rn    = insn[9:5];
    assign rd    = insn[4:0];

    // Format recognition from the class bits and bit 21
    always_comb begin
        if (insn[28:24] == 5'b10001)
            fmt = FMT_IMM;
        else if (insn[28:24] == 5'b01011)
            fmt = insn[21] ? FMT_XREG : FMT_SREG;
        else
            fmt = FMT_NONE;
    end

    // Reserved-encoding checks, one rule set per format
    always_comb begin
        unique case (fmt)
            FMT_IMM:  bad = kind[1];
            FMT_SREG: bad = (kind == 2'b11) || (!wide && amt6[5]);
            FMT_XREG: bad = (xamt > 3'd4);
            default:  bad = 1'b1;
        endcase
    end

    assign sp_format = (fmt == FMT_IMM) || (fmt == FMT_XREG);

    // Register 31 interpretation for each operand position
    always_comb begin
        rn_is_sp = sp_format && (rn == REG31);
        rn_zero  = (fmt == FMT_SREG) && (rn == REG31);
        rm_zero  = (rm == REG31);
        rd_sp    = sp_format && (rd == REG31) && !setf;
        rd_drop  = (rd == REG31) && ((fmt == FMT_SREG) || setf);
    end
endmodule

// File: rtl/addsub_operand.sv
// Second-operand builder: scaled immediate, shifted register or
// extended-and-shifted register, limited to the active width.
// Assumes XLEN is 64 so the 6-bit shift field spans the full width.
module addsub_operand
    import addsub_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  fmt_e             fmt,
    input  logic             wide,
    input  logic [XLEN-1:0]  rm_data,
    input  logic             rm_zero,
    input  logic [1:0]       kind,
    input  logic [5:0]       amt6,
    input  logic [2:0]       xopt,
    input  logic [2:0]       xamt,
    input  logic [11:0]      imm12,
    output logic [XLEN-1:0]  opb
);
    localparam int HALF = XLEN / 2;
    localparam int SHW  = $clog2(XLEN);
    localparam int HSHW = $clog2(HALF);
    localparam int NEXT = 4;

    logic [XLEN-1:0] src;
    logic [XLEN-1:0] imm_val;
    logic [XLEN-1:0] shf_val;
    logic [XLEN-1:0] ext_val;
    logic [XLEN-1:0] ext_cand [NEXT];
    logic [HALF-1:0] lo;
    logic [HALF-1:0] lo_shf;

    // Register source with zero-register and width masking applied
    always_comb begin
        src = rm_zero ? '0 : rm_data;
        if (!wide)
            src = {{(XLEN-HALF){1'b0}}, src[HALF-1:0]};
    end

    assign lo = src[HALF-1:0];

    // Immediate scaling: code 01 moves it up by twelve
    always_comb begin
        imm_val = {{(XLEN-12){1'b0}}, imm12};
        if (kind[0])
            imm_val = imm_val << 12;
    end

    // Narrow shifter on the low half
    always_comb begin
        unique case (kind)
            2'b01:   lo_shf = lo >> amt6[HSHW-1:0];
            2'b10:   lo_shf = HALF'($signed(lo) >>> amt6[HSHW-1:0]);
            default: lo_shf = lo << amt6[HSHW-1:0];
        endcase
    end

    // Full-width shifter, narrow result zero-extended
    always_comb begin
        if (wide) begin
            unique case (kind)
                2'b01:   shf_val = src >> amt6[SHW-1:0];
                2'b10:   shf_val = XLEN'($signed(src) >>> amt6[SHW-1:0]);
                default: shf_val = src << amt6[SHW-1:0];
            endcase
        end else begin
            shf_val = {{(XLEN-HALF){1'b0}}, lo_shf};
        end
    end

    // One extension candidate per source size: 8, 16, 32, 64 bits
    for (genvar g = 0; g < NEXT; g++) begin : g_ext
        localparam int SZ = 8 << g;
        if (SZ >= XLEN) begin : g_full
            assign ext_cand[g] = src;
        end else begin : g_part
            assign ext_cand[g] = xopt[2]
                ? {{(XLEN-SZ){src[SZ-1]}}, src[SZ-1:0]}
                : {{(XLEN-SZ){1'b0}}, src[SZ-1:0]};
        end
    end

    // Extension select, left shift, width trim
    always_comb begin
        ext_val = ext_cand[xopt[1:0]] << xamt;
        if (!wide)
            ext_val = {{(XLEN-HALF){1'b0}}, ext_val[HALF-1:0]};
    end

    // Format selects the operand
    always_comb begin
        unique case (fmt)
            FMT_IMM:  opb = imm_val;
            FMT_SREG: opb = shf_val;
            FMT_XREG: opb = ext_val;
            default:  opb = '0;
        endcase
    end
endmodule

// File: rtl/addsub_alu.sv
// Add/subtract core with NZCV generation at either full or half width.
// Subtract is a + ~b + 1, so carry means no borrow. Narrow results are
// zero-extended. Combinational.
module addsub_alu #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            sub,
    input  logic            wide,
    output logic [XLEN-1:0] result,
    output logic [3:0]      nzcv
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] bx;
    logic [XLEN:0]   sum_w;
    logic [HALF:0]   sum_n;
    logic            sa, sb, sr, cy;

    assign bx = sub ? ~b : b;

    // Full and half adders share the inverted operand
    always_comb begin
        sum_w = {1'b0, a} + {1'b0, bx} + {{XLEN{1'b0}}, sub};
        sum_n = {1'b0, a[HALF-1:0]} + {1'b0, bx[HALF-1:0]} + {{HALF{1'b0}}, sub};
    end

    // Width select of result and sign/carry sources
    always_comb begin
        if (wide) begin
            result = sum_w[XLEN-1:0];
            cy = sum_w[XLEN];
            sa = a[XLEN-1];
            sb = bx[XLEN-1];
        end else begin
            result = {{(XLEN-HALF){1'b0}}, sum_n[HALF-1:0]};
            cy = sum_n[HALF];
            sa = a[HALF-1];
            sb = bx[HALF-1];
        end
        sr = wide ? result[XLEN-1] : result[HALF-1];
        nzcv = {sr, (result == '0), cy, (sa == sb) && (sr != sa)};
    end
endmodule

// File: rtl/addsub_exec.sv
// Top of the add/subtract decode-execute unit. Read addresses follow the
// word combinationally; read data is expected in the same cycle. The
// write-back, flag update and undefined pulse are registered, one clock
// after the valid strobe.
module addsub_exec
    import addsub_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_valid,
    input  logic [INSN_W-1:0]  insn,
    output logic [RADDR_W-1:0] rd_addr_a,
    output logic               rd_sp_a,
    input  logic [XLEN-1:0]    rd_data_a,
    output logic [RADDR_W-1:0] rd_addr_b,
    input  logic [XLEN-1:0]    rd_data_b,
    output logic               wb_en,
    output logic [RADDR_W-1:0] wb_addr,
    output logic               wb_sp,
    output logic [XLEN-1:0]    wb_data,
    output logic               flags_we,
    output logic [3:0]         flags,
    output logic               undef
);
    fmt_e               fmt;
    logic               wide, sub, setf, bad;
    logic               rn_is_sp, rn_zero, rm_zero, rd_sp, rd_drop;
    logic [RADDR_W-1:0] rn, rm, rd;
    logic [1:0]         kind;
    logic [5:0]         amt6;
    logic [2:0]         xopt, xamt;
    logic [11:0]        imm12;
    logic [XLEN-1:0]    opa, opb, result;
    logic [3:0]         nzcv;

    addsub_decode u_dec (
        .insn     (insn),
        .fmt      (fmt),
        .wide     (wide),
        .sub      (sub),
        .setf     (setf),
        .rn       (rn),
        .rm       (rm),
        .rd       (rd),
        .kind     (kind),
        .amt6     (amt6),
        .xopt     (xopt),
        .xamt     (xamt),
        .imm12    (imm12),
        .bad      (bad),
        .rn_is_sp (rn_is_sp),
        .rn_zero  (rn_zero),
        .rm_zero  (rm_zero),
        .rd_sp    (rd_sp),
        .rd_drop  (rd_drop)
    );

    assign rd_addr_a = rn;
    assign rd_sp_a   = rn_is_sp;
    assign rd_addr_b = rm;

    // First operand: zero register forced locally, width handled by core
    assign opa = rn_zero ? '0 : rd_data_a;

    addsub_operand #(.XLEN(XLEN)) u_opb (
        .fmt     (fmt),
        .wide    (wide),
        .rm_data (rd_data_b),
        .rm_zero (rm_zero),
        .kind    (kind),
        .amt6    (amt6),
        .xopt    (xopt),
        .xamt    (xamt),
        .imm12   (imm12),
        .opb     (opb)
    );

    addsub_alu #(.XLEN(XLEN)) u_alu (
        .a      (opa),
        .b      (opb),
        .sub    (sub),
        .wide   (wide),
        .result (result),
        .nzcv   (nzcv)
    );

    // Result stage: pulses, write-back fields and the flag register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en    <= 1'b0;
            wb_addr  <= '0;
            wb_sp    <= 1'b0;
            wb_data  <= '0;
            flags_we <= 1'b0;
            flags    <= 4'b0;
            undef    <= 1'b0;
        end else begin
            wb_en    <= 1'b0;
            flags_we <= 1'b0;
            undef    <= 1'b0;
            if (insn_valid) begin
                if (bad) begin
                    undef <= 1'b1;
                end else begin
                    wb_en   <= !rd_drop;
                    wb_addr <= rd;
                    wb_sp   <= rd_sp;
                    wb_data <= result;
                    if (setf) begin
                        flags_we <= 1'b1;
                        flags    <= nzcv;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/addsub_exec_checker.sv
// Property checker for addsub_exec, attached by bind below.
module addsub_exec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_valid,
    input logic        insn_wide,
    input logic [4:0]  rd_addr_a,
    input logic        rd_sp_a,
    input logic        wb_en,
    input logic [4:0]  wb_addr,
    input logic        wb_sp,
    input logic [31:0] wb_hi,
    input logic        flags_we,
    input logic [3:0]  flags,
    input logic        undef
);
    p_wb_after_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> $past(insn_valid));

    p_undef_after_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> $past(insn_valid));

    p_flagwe_after_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> $past(insn_valid));

    p_undef_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (!wb_en && !flags_we));

    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_we |-> $stable(flags));

    p_sp_dest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_sp) |-> (wb_addr == 5'd31));

    p_sp_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sp_a |-> (rd_addr_a == 5'd31));

    p_narrow_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !$past(insn_wide)) |-> (wb_hi == 32'd0));
endmodule

bind addsub_exec addsub_exec_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_valid (insn_valid),
    .insn_wide  (insn[31]),
    .rd_addr_a  (rd_addr_a),
    .rd_sp_a    (rd_sp_a),
    .wb_en      (wb_en),
    .wb_addr    (wb_addr),
    .wb_sp      (wb_sp),
    .wb_hi      (wb_data[63:32]),
    .flags_we   (flags_we),
    .flags      (flags),
    .undef      (undef)
);

// File: tb/addsub_exec_test.sv
module addsub_exec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn = 32'd0;
    logic [4:0]  rd_addr_a, rd_addr_b, wb_addr;
    logic        rd_sp_a, wb_en, wb_sp, flags_we, undef;
    logic [63:0] rd_data_a, rd_data_b, wb_data;
    logic [3:0]  flags;

    logic [63:0] regs [32];
    logic [63:0] sp_val;
    logic [3:0]  exp_flags;
    int checks = 0;
    int errors = 0;

    addsub_exec uut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .rd_addr_a(rd_addr_a), .rd_sp_a(rd_sp_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_sp(wb_sp), .wb_data(wb_data),
        .flags_we(flags_we), .flags(flags), .undef(undef)
    );

    always #5 clk = ~clk;

    // Register file model with same-cycle read
    always_comb begin
        rd_data_a = rd_sp_a ? sp_val : regs[rd_addr_a];
        rd_data_b = regs[rd_addr_b];
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_imm(bit sf, bit op, bit s, logic [1:0] sh,
                                            logic [11:0] imm, logic [4:0] rn, logic [4:0] rd);
        return {sf, op, s, 5'b10001, sh, imm, rn, rd};
    endfunction

    function automatic logic [31:0] enc_sr(bit sf, bit op, bit s, logic [1:0] typ,
                                           logic [5:0] amt, logic [4:0] rm, logic [4:0] rn, logic [4:0] rd);
        return {sf, op, s, 5'b01011, typ, 1'b0, rm, amt, rn, rd};
    endfunction

    function automatic logic [31:0] enc_xr(bit sf, bit op, bit s, logic [2:0] opt,
                                           logic [2:0] amt, logic [4:0] rm, logic [4:0] rn, logic [4:0] rd);
        return {sf, op, s, 5'b01011, 2'b00, 1'b1, rm, opt, amt, rn, rd};
    endfunction

    // Reference behaviour written from the requirements
    function automatic void model(input logic [31:0] w,
                                  output bit e_undef, output bit e_wen, output bit e_wsp,
                                  output bit e_fwe, output logic [4:0] e_addr,
                                  output logic [63:0] e_data, output logic [3:0] e_nzcv);
        bit sf = w[31], op = w[30], s = w[29];
        logic [4:0] rd = w[4:0], rn = w[9:5], rm = w[20:16];
        logic [63:0] mask = sf ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        logic [63:0] a, b, m, r;
        logic [64:0] t;
        logic signed [31:0] s32;
        logic signed [63:0] s64;
        int kind, sb;
        bit c, v, n;
        if (w[28:24] == 5'b10001) kind = 1;
        else if (w[28:24] == 5'b01011) kind = w[21] ? 3 : 2;
        else kind = 0;
        e_undef = 0; e_wen = 0; e_wsp = 0; e_fwe = 0; e_addr = rd; e_data = 0; e_nzcv = 0;
        case (kind)
            0: e_undef = 1;
            1: e_undef = w[23];
            2: e_undef = (w[23:22] == 2'b11) || (!sf && w[15:10] > 31);
            default: e_undef = (w[12:10] > 4);
        endcase
        if (e_undef) return;
        if (rn == 31) a = (kind == 2) ? 64'd0 : sp_val;
        else a = regs[rn];
        a &= mask;
        m = (rm == 31) ? 64'd0 : (regs[rm] & mask);
        if (kind == 1) begin
            b = {52'd0, w[21:10]};
            if (w[22]) b = b << 12;
        end else if (kind == 2) begin
            case (w[23:22])
                2'b00: b = (m << w[15:10]) & mask;
                2'b01: b = m >> w[15:10];
                default: begin
                    if (sf) begin s64 = m; s64 = s64 >>> w[15:10]; b = s64; end
                    else begin s32 = m[31:0]; s32 = s32 >>> w[15:10]; b = {32'd0, s32}; end
                end
            endcase
        end else begin
            case (w[14:13])
                2'd0: b = w[15] ? {{56{m[7]}}, m[7:0]} : {56'd0, m[7:0]};
                2'd1: b = w[15] ? {{48{m[15]}}, m[15:0]} : {48'd0, m[15:0]};
                2'd2: b = w[15] ? {{32{m[31]}}, m[31:0]} : {32'd0, m[31:0]};
                default: b = m;
            endcase
            b = (b << w[12:10]) & mask;
        end
        sb = sf ? 63 : 31;
        if (!op) begin
            t = {1'b0, a} + {1'b0, b};
            c = sf ? t[64] : t[32];
            r = t[63:0] & mask;
            v = (a[sb] == b[sb]) && (r[sb] != a[sb]);
        end else begin
            r = (a - b) & mask;
            c = (a >= b);
            v = (a[sb] != b[sb]) && (r[sb] != a[sb]);
        end
        n = r[sb];
        e_data = r;
        e_nzcv = {n, (r == 0), c, v};
        e_fwe = s;
        if (rd == 31) begin
            if (kind == 2 || s) e_wen = 0;
            else begin e_wen = 1; e_wsp = 1; end
        end else begin
            e_wen = 1;
        end
    endfunction

    // Apply one word at a negedge; check results at the following negedge
    task automatic run_insn(input logic [31:0] w, input string tag);
        bit eu, ew, es, ef;
        logic [4:0] ea;
        logic [63:0] ed;
        logic [3:0] en;
        insn = w;
        insn_valid = 1'b1;
        model(w, eu, ew, es, ef, ea, ed, en);
        @(negedge clk);
        insn_valid = 1'b0;
        chk(tag, "undef", {63'd0, undef}, {63'd0, eu});
        chk(tag, "wb_en", {63'd0, wb_en}, {63'd0, ew});
        chk(tag, "flags_we", {63'd0, flags_we}, {63'd0, ef});
        if (ew) begin
            chk(tag, "wb_addr", {59'd0, wb_addr}, {59'd0, ea});
            chk(tag, "wb_sp", {63'd0, wb_sp}, {63'd0, es});
            chk(tag, "wb_data", wb_data, ed);
        end
        if (ef) exp_flags = en;
        chk(tag, "flags", {60'd0, flags}, {60'd0, exp_flags});
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        chk(tag, "idle pulses", {61'd0, wb_en, flags_we, undef}, 64'd0);
        chk(tag, "idle flags", {60'd0, flags}, {60'd0, exp_flags});
    endtask

    function automatic logic [63:0] rand_val();
        case ($urandom % 6)
            0: return 64'd0;
            1: return 64'hFFFF_FFFF_FFFF_FFFF;
            2: return 64'h8000_0000_0000_0000;
            3: return {32'h0, $urandom};
            default: return {$urandom, $urandom};
        endcase
    endfunction

    function automatic logic [4:0] rand_reg();
        return ($urandom % 8 == 0) ? 5'd31 : 5'($urandom % 32);
    endfunction

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 32; i++) regs[i] = rand_val();
        regs[31] = 64'hBAD0_BAD0_BAD0_BAD0;
        sp_val = 64'h0000_7FFF_FFF0_0100;
        exp_flags = 4'b0;

        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "reset pulses", {61'd0, wb_en, flags_we, undef}, 64'd0);
        chk("R8", "reset flags", {60'd0, flags}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R8: 64-bit signed overflow through the immediate form
        regs[1] = 64'h7FFF_FFFF_FFFF_FFFF;
        run_insn(enc_imm(1, 0, 1, 2'b00, 12'd1, 5'd1, 5'd2), "R2");
        // R2: immediate shifted by twelve
        regs[4] = 64'd100;
        run_insn(enc_imm(1, 0, 0, 2'b01, 12'hABC, 5'd4, 5'd3), "R2");
        // R2: reserved shift codes
        run_insn(enc_imm(1, 0, 0, 2'b10, 12'h001, 5'd4, 5'd3), "R2");
        run_insn(enc_imm(0, 1, 1, 2'b11, 12'h001, 5'd4, 5'd3), "R2");
        // R8 / R7: 32-bit compare to equal gives Z and C
        regs[5] = 64'hFFFF_0000_0000_0005;
        run_insn(enc_imm(0, 1, 1, 2'b00, 12'd5, 5'd5, 5'd6), "R8");
        // R7: 32-bit wrap with garbage in the upper half
        regs[6] = 64'hDEAD_BEEF_FFFF_FFFF;
        run_insn(enc_imm(0, 0, 1, 2'b00, 12'd1, 5'd6, 5'd7), "R7");
        // R1: non-flag subtract keeps the flags
        run_insn(enc_imm(1, 1, 0, 2'b00, 12'd7, 5'd4, 5'd8), "R1");
        idle_check("R10");
        // R5: stack pointer adjust
        run_insn(enc_imm(1, 0, 0, 2'b00, 12'd16, 5'd31, 5'd31), "R5");
        // R5: flag-setting form drops the write to 31
        run_insn(enc_imm(1, 0, 1, 2'b00, 12'd16, 5'd31, 5'd31), "R5");
        // R5: extended form reads the stack pointer
        run_insn(enc_xr(1, 1, 0, 3'b011, 3'd0, 5'd4, 5'd31, 5'd9), "R5");
        // R6: zero register as base and destination
        regs[8] = 64'd3;
        run_insn(enc_sr(1, 1, 1, 2'b00, 6'd0, 5'd8, 5'd31, 5'd7), "R6");
        run_insn(enc_sr(1, 0, 0, 2'b00, 6'd0, 5'd8, 5'd4, 5'd31), "R6");
        run_insn(enc_sr(1, 0, 0, 2'b00, 6'd0, 5'd31, 5'd4, 5'd10), "R6");
        // R3: each shift kind and the reserved cases
        regs[11] = 64'hF000_0000_0000_0010;
        run_insn(enc_sr(1, 0, 0, 2'b10, 6'd4, 5'd11, 5'd4, 5'd12), "R3");
        run_insn(enc_sr(1, 0, 0, 2'b01, 6'd63, 5'd11, 5'd4, 5'd12), "R3");
        run_insn(enc_sr(0, 0, 0, 2'b10, 6'd31, 5'd5, 5'd4, 5'd12), "R3");
        run_insn(enc_sr(0, 0, 1, 2'b00, 6'd31, 5'd5, 5'd4, 5'd12), "R3");
        run_insn(enc_sr(1, 0, 0, 2'b11, 6'd1, 5'd11, 5'd4, 5'd12), "R3");
        run_insn(enc_sr(0, 0, 0, 2'b00, 6'd32, 5'd11, 5'd4, 5'd12), "R3");
        // R4: sign-extended byte with shift, word zero-extend, reserved amount
        regs[13] = 64'h0000_0000_0000_0080;
        run_insn(enc_xr(1, 0, 0, 3'b100, 3'd2, 5'd13, 5'd4, 5'd14), "R4");
        run_insn(enc_xr(1, 0, 0, 3'b010, 3'd4, 5'd11, 5'd4, 5'd14), "R4");
        run_insn(enc_xr(1, 1, 1, 3'b110, 3'd1, 5'd11, 5'd4, 5'd14), "R4");
        run_insn(enc_xr(1, 0, 0, 3'b000, 3'd5, 5'd13, 5'd4, 5'd14), "R4");
        // R9: unrecognized words
        run_insn(32'h0000_0000, "R9");
        run_insn(32'hF200_0000, "R9");
        idle_check("R10");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            string tag;
            bit sf = 1'($urandom);
            int pick = $urandom % 8;
            if (i % 200 == 0) regs[$urandom % 31] = rand_val();
            if (pick < 2) begin
                logic [1:0] sh = ($urandom % 5 == 0) ? 2'(2 + $urandom % 2) : 2'($urandom % 2);
                w = enc_imm(sf, 1'($urandom), 1'($urandom), sh, 12'($urandom),
                            rand_reg(), rand_reg());
                tag = "R2";
            end else if (pick < 5) begin
                logic [1:0] typ = ($urandom % 6 == 0) ? 2'b11 : 2'($urandom % 3);
                logic [5:0] amt = sf ? 6'($urandom)
                                     : (($urandom % 8 == 0) ? 6'(32 + $urandom % 32) : 6'($urandom % 32));
                w = enc_sr(sf, 1'($urandom), 1'($urandom), typ, amt,
                           rand_reg(), rand_reg(), rand_reg());
                tag = "R3";
            end else if (pick < 7) begin
                logic [2:0] a3 = ($urandom % 6 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
                w = enc_xr(sf, 1'($urandom), 1'($urandom), 3'($urandom), a3,
                           rand_reg(), rand_reg(), rand_reg());
                tag = "R4";
            end else begin
                w = $urandom;
                if (w[28:24] == 5'b10001 || w[28:24] == 5'b01011) w[28:24] = 5'b00000;
                tag = "R9";
            end
            run_insn(w, tag);
            if ($urandom % 16 == 0) idle_check("R10");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule